// File: doc/BRIEF.md
# Flash Program and Erase Sequencer with Page Buffer

This block runs the program and erase operations of an on-chip code memory. The memory is modelled as a synchronous byte array made of 1 kB sectors, and each sector is split into 64-byte pages. Software issues commands through a small command port: load a byte into the page buffer, program the buffered page, or erase a byte, a page, a sector or the whole array. A 64-byte page buffer keeps one valid flag for each byte. A single program operation therefore writes any subset of 1 to 64 bytes of one page, and every byte that was not loaded keeps its contents.

Every program or erase spends a fixed number of clock cycles in a timing phase. The block then commits the result into the array, one byte per two cycles. A brown-out input stops any new operation from starting. If brown-out appears during the timing phase, the operation is aborted before any byte is committed. Both cases raise sticky error bits. A finished operation raises a done flag that software must clear, and that flag drives an interrupt when the interrupt enable is high. The array can be read with one cycle of latency, but only while the block is idle.

Top module: `flash_seq`

## Requirements
- R1: `cmd_op` = 1 (load) loads `cmd_data` into the page buffer at the offset given by `cmd_addr`. When the buffer holds no valid byte, the load also latches the page of `cmd_addr`. A load into any other page while bytes are valid is rejected, and the buffer is left unchanged.
- R2: `cmd_op` = 2 (program) commits each valid buffered byte into the latched page as the bitwise AND with the stored byte. Bytes that were not loaded stay unchanged. All valid flags clear when the operation completes. A program issued with an empty buffer starts nothing.
- R3: Erase commands set every affected byte to 0xFF and leave every other byte unchanged. The codes are: `cmd_op` = 3 erases the byte at `cmd_addr`; 4 erases its 64-byte page; 5 erases its 1 kB sector; 6 erases the whole array. Code 0 is no operation.
- R4: An accepted operation holds `busy` for OP_CYCLES + 2×N cycles, where N is the number of bytes it covers (64 for a program).
- R5: Every command issued while `busy` is high is ignored, including loads.
- R6: A program or erase issued while `brownout` is high starts nothing and leaves the array unchanged. It sets `err_flags[0]` and does not set `done_flag`.
- R7: If `brownout` is high during the timing phase, the operation aborts. `busy` is low one cycle later, the array is unchanged, `err_flags[1]` is set and `done_flag` stays low. The buffer keeps its contents.
- R8: `done_flag` sets when an operation completes and clears only when `done_clr` is pulsed. `irq` equals `done_flag` AND `int_en`.
- R9: Each bit of `err_flags` stays set until reset or until the matching bit of `err_clr` is pulsed.
- R10: `rd_en` while idle returns the byte at `rd_addr` on `rd_data` with `rd_valid` one cycle later. `rd_en` while `busy` is high gives no `rd_valid`.
- R11: After reset, `busy`, `done_flag`, `irq`, `err_flags` and `rd_valid` are low, and the page buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or watchdog) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | AW | Byte address of the command |
| cmd_data | input | 8 | Byte for a buffer load |
| rd_en | input | 1 | Array read request |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| brownout | input | 1 | Supply low, blocks program and erase |
| int_en | input | 1 | Interrupt enable |
| done_clr | input | 1 | Clears the done flag |
| err_clr | input | 2 | Write-one-to-clear for the error bits |
| busy | output | 1 | Operation in progress |
| done_flag | output | 1 | Operation completed |
| irq | output | 1 | Completion interrupt |
| err_flags | output | 2 | [0] start blocked, [1] operation aborted |

## Verification
The bench tests the byte-level effects of programming. A design that overwrites instead of ANDing would show 0xF0 where 0x30 is expected. A design that programs unloaded offsets would corrupt the neighbouring bytes. A design that accepts a load into a second page would write 0x00 at an address that must stay 0xFF.

The bench also counts the exact busy length for a one-byte erase and for a program. An off-by-one in the timer or in the commit walk would change that count. A brown-out is tested at the moment of issue and again mid-operation. The array must stay unchanged in both cases, and the done flag must stay low. A design that committed before timing, or that flagged completion after an abort, would fail these checks.

Loads, erases and reads issued while busy are checked to have no effect. A program with an empty buffer, issued right after a successful program, must start nothing. A design that kept the valid flags would start an operation there.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_PROG  = 3'd2,
        OP_ERB   = 3'd3,
        OP_ERP   = 3'd4,
        OP_ERS   = 3'd5,
        OP_ERC   = 3'd6,
        OP_RSV   = 3'd7
    } fseq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } fseq_state_e;

endpackage

// File: rtl/fseq_array.sv
module fseq_array #(
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int CYCLES = 250000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = run && (cnt_q == CW'(CYCLES - 1));
        if (start)                cnt_d = '0;
        else if (run && !expire)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CYCLES - 1));
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == '0));
endmodule

// File: rtl/fseq_pagebuf.sv
module fseq_pagebuf #(
    parameter int AW         = 12,
    parameter int PAGE_BYTES = 64,
    localparam int OW        = $clog2(PAGE_BYTES),
    localparam int PW        = AW - OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic          clr,
    input  logic [OW-1:0] rd_off,
    output logic [7:0]    rd_byte,
    output logic          rd_flag,
    output logic [PW-1:0] page,
    output logic          any_valid
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      vld;
        logic [PW-1:0]              page;
    } buf_t;

    buf_t d, q;
    logic hit, ld_ok;
    logic [OW-1:0] off;

    always_comb begin
        d     = q;
        off   = ld_addr[OW-1:0];
        hit   = (ld_addr[AW-1:OW] == q.page);
        ld_ok = ld_en && (!(|q.vld) || hit);
        if (clr) begin
            d.vld = '0;
        end else if (ld_ok) begin
            if (!(|q.vld)) d.page = ld_addr[AW-1:OW];
            d.data[off] = ld_data;
            d.vld[off]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_byte   = q.data[rd_off];
    assign rd_flag   = q.vld[rd_off];
    assign page      = q.page;
    assign any_valid = |q.vld;

    assert_reject_keeps_buffer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !clr && (|q.vld) && !hit) |=> ($stable(q.vld) && $stable(q.data) && $stable(q.page)));
    assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import fseq_pkg::*;
#(
    parameter int NUM_SECTORS  = 4,
    parameter int SECTOR_BYTES = 1024,
    parameter int PAGE_BYTES   = 64,
    parameter int OP_CYCLES    = 250000,
    localparam int DEPTH       = NUM_SECTORS * SECTOR_BYTES,
    localparam int AW          = $clog2(DEPTH),
    localparam int OW          = $clog2(PAGE_BYTES),
    localparam int SW          = $clog2(SECTOR_BYTES),
    localparam int PW          = AW - OW,
    localparam int CW          = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    input  logic          brownout,
    input  logic          int_en,
    input  logic          done_clr,
    input  logic [1:0]    err_clr,
    output logic          busy,
    output logic          done_flag,
    output logic          irq,
    output logic [1:0]    err_flags
);
    typedef struct packed {
        fseq_state_e   st;
        logic [AW-1:0] base;
        logic [CW-1:0] idx;
        logic [CW-1:0] len;
        logic          prog;
        logic          done;
        logic [1:0]    err;
        logic          rvld;
    } ctl_t;

    ctl_t d, q;

    logic          ram_we;
    logic [7:0]    ram_wdata, ram_rdata;
    logic [AW-1:0] ram_addr;
    logic          buf_ld, buf_clr, buf_flag, buf_any;
    logic [7:0]    buf_byte;
    logic [PW-1:0] buf_page;
    logic          tmr_start, tmr_expire;
    logic          is_work;
    fseq_op_e      op;

    fseq_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .addr  (ram_addr),
        .we    (ram_we),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    fseq_pagebuf #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (buf_ld),
        .ld_addr   (cmd_addr),
        .ld_data   (cmd_data),
        .clr       (buf_clr),
        .rd_off    (q.idx[OW-1:0]),
        .rd_byte   (buf_byte),
        .rd_flag   (buf_flag),
        .page      (buf_page),
        .any_valid (buf_any)
    );

    fseq_timer #(.CYCLES(OP_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (q.st == ST_WAIT),
        .expire (tmr_expire)
    );

    assign op      = fseq_op_e'(cmd_op);
    assign is_work = (cmd_op >= 3'd2) && (cmd_op <= 3'd6);
    assign buf_ld  = cmd_valid && (q.st == ST_IDLE) && (op == OP_LOAD);
    assign ram_addr = ((q.st == ST_RD) || (q.st == ST_WR)) ? (q.base + q.idx[AW-1:0]) : rd_addr;

    always_comb begin
        d         = q;
        d.rvld    = rd_en && (q.st == ST_IDLE);
        ram_we    = 1'b0;
        ram_wdata = 8'hFF;
        buf_clr   = 1'b0;
        tmr_start = 1'b0;
        if (done_clr) d.done = 1'b0;
        d.err = q.err & ~err_clr;

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid && is_work) begin
                    if (brownout) begin
                        d.err[0] = 1'b1;
                    end else if (!((op == OP_PROG) && !buf_any)) begin
                        d.st      = ST_WAIT;
                        d.idx     = '0;
                        d.prog    = (op == OP_PROG);
                        tmr_start = 1'b1;
                        case (op)
                            OP_PROG: begin
                                d.base = {buf_page, {OW{1'b0}}};
                                d.len  = CW'(PAGE_BYTES);
                            end
                            OP_ERB: begin
                                d.base = cmd_addr;
                                d.len  = CW'(1);
                            end
                            OP_ERP: begin
                                d.base = {cmd_addr[AW-1:OW], {OW{1'b0}}};
                                d.len  = CW'(PAGE_BYTES);
                            end
                            OP_ERS: begin
                                d.base = {cmd_addr[AW-1:SW], {SW{1'b0}}};
                                d.len  = CW'(SECTOR_BYTES);
                            end
                            default: begin
                                d.base = '0;
                                d.len  = CW'(DEPTH);
                            end
                        endcase
                    end
                end
            end
            ST_WAIT: begin
                if (brownout) begin
                    d.st     = ST_IDLE;
                    d.err[1] = 1'b1;
                end else if (tmr_expire) begin
                    d.st = ST_RD;
                end
            end
            ST_RD: begin
                d.st = ST_WR;
            end
            ST_WR: begin
                if (q.prog) begin
                    ram_we    = buf_flag;
                    ram_wdata = ram_rdata & buf_byte;
                end else begin
                    ram_we    = 1'b1;
                end
                if (q.idx == (q.len - 1'b1)) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    buf_clr = q.prog;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.st  = ST_RD;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done_flag = q.done;
    assign irq       = q.done & int_en;
    assign err_flags = q.err;
    assign rd_valid  = q.rvld;
    assign rd_data   = ram_rdata;

    assert_read_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> !rd_valid);
    assert_brownout_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && is_work && brownout) |=> (!busy && err_flags[0]));
    assert_abort_midop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_WAIT) && brownout) |=> (!busy && err_flags[1] && !$rose(done_flag)));
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag);
    assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(q.st == ST_WR));
    assert_err0_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[0] && !err_clr[0]) |=> err_flags[0]);
    assert_err1_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[1] && !err_clr[1]) |=> err_flags[1]);
    assert_no_write_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_WR) |-> !ram_we);
endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;
    localparam int AW  = 12;
    localparam int OPC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          brownout = 1'b0;
    logic          int_en = 1'b0;
    logic          done_clr = 1'b0;
    logic [1:0]    err_clr = '0;
    logic          busy, done_flag, irq;
    logic [1:0]    err_flags;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_seq #(.NUM_SECTORS(4), .SECTOR_BYTES(1024), .PAGE_BYTES(64), .OP_CYCLES(OPC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .brownout(brownout), .int_en(int_en),
        .done_clr(done_clr), .err_clr(err_clr), .busy(busy), .done_flag(done_flag),
        .irq(irq), .err_flags(err_flags)
    );

    // op, addr, data, probe address, expected probe byte
    localparam int NV = 28;
    localparam logic [42:0] TBL [NV] = '{
        {3'd1, 12'h045, 8'h3C, 12'h045, 8'hFF},
        {3'd1, 12'h047, 8'hA5, 12'h047, 8'hFF},
        {3'd1, 12'h0C0, 8'h00, 12'h0C0, 8'hFF},
        {3'd2, 12'h000, 8'h00, 12'h045, 8'h3C},
        {3'd0, 12'h000, 8'h00, 12'h047, 8'hA5},
        {3'd0, 12'h000, 8'h00, 12'h0C0, 8'hFF},
        {3'd0, 12'h000, 8'h00, 12'h046, 8'hFF},
        {3'd1, 12'h045, 8'hF0, 12'h045, 8'h3C},
        {3'd2, 12'h000, 8'h00, 12'h045, 8'h30},
        {3'd3, 12'h047, 8'h00, 12'h047, 8'hFF},
        {3'd0, 12'h000, 8'h00, 12'h045, 8'h30},
        {3'd1, 12'h400, 8'h11, 12'h400, 8'hFF},
        {3'd1, 12'h43F, 8'h22, 12'h43F, 8'hFF},
        {3'd2, 12'h000, 8'h00, 12'h43F, 8'h22},
        {3'd0, 12'h000, 8'h00, 12'h400, 8'h11},
        {3'd1, 12'h440, 8'h33, 12'h440, 8'hFF},
        {3'd2, 12'h000, 8'h00, 12'h440, 8'h33},
        {3'd4, 12'h410, 8'h00, 12'h400, 8'hFF},
        {3'd0, 12'h000, 8'h00, 12'h43F, 8'hFF},
        {3'd0, 12'h000, 8'h00, 12'h440, 8'h33},
        {3'd1, 12'h7FF, 8'h44, 12'h7FF, 8'hFF},
        {3'd2, 12'h000, 8'h00, 12'h7FF, 8'h44},
        {3'd1, 12'h800, 8'h55, 12'h800, 8'hFF},
        {3'd2, 12'h000, 8'h00, 12'h800, 8'h55},
        {3'd5, 12'h5AB, 8'h00, 12'h440, 8'hFF},
        {3'd0, 12'h000, 8'h00, 12'h7FF, 8'hFF},
        {3'd0, 12'h000, 8'h00, 12'h800, 8'h55},
        {3'd0, 12'h000, 8'h00, 12'h045, 8'h30}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic [AW-1:0] a, input logic [7:0] dt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = o; cmd_addr = a; cmd_data = dt;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic vl);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data; vl = rd_valid;
    endtask

    task automatic pulse_done_clr();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic pulse_err_clr(input logic [1:0] m);
        @(negedge clk); err_clr = m;
        @(negedge clk); err_clr = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired, actual busy %0b expected 0", busy);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       vl;
        int         n;
        logic [2:0] o;

        int_en = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 busy", busy, 0);
        chk("R11 done", done_flag, 0);
        chk("R11 irq", irq, 0);
        chk("R11 err", err_flags, 0);
        chk("R11 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        int_en = 1'b0;
        // R11: buffer empty, so program starts nothing
        issue(3'd2, '0, '0);
        chk("R11 empty buffer", busy, 0);

        // R3: chip erase brings array to known state
        issue(3'd6, '0, '0);
        wait_idle();

        for (int i = 0; i < NV; i++) begin
            o = TBL[i][42:40];
            issue(o, TBL[i][39:28], TBL[i][27:20]);
            wait_idle();
            rd(TBL[i][19:8], v, vl);
            if (o == 3'd1)      chk("R1 table", {vl, v}, {1'b1, TBL[i][7:0]});
            else if (o == 3'd2) chk("R2 table", {vl, v}, {1'b1, TBL[i][7:0]});
            else                chk("R3 table", {vl, v}, {1'b1, TBL[i][7:0]});
        end

        // R4: busy length for a one-byte erase and for a program
        issue(3'd3, 12'h100, '0);
        n = 0;
        while (busy && n < 50000) begin n++; @(negedge clk); end
        chk("R4 erase byte busy cycles", n, OPC + 2);
        issue(3'd1, 12'h123, 8'h0F);
        issue(3'd2, '0, '0);
        n = 0;
        while (busy && n < 50000) begin n++; @(negedge clk); end
        chk("R4 program busy cycles", n, OPC + 128);

        // R8: done flag and interrupt gating
        chk("R8 done set", done_flag, 1);
        chk("R8 irq masked", irq, 0);
        @(negedge clk); int_en = 1'b1;
        @(negedge clk);
        chk("R8 irq enabled", irq, 1);
        repeat (5) @(negedge clk);
        chk("R8 done held", done_flag, 1);
        pulse_done_clr();
        chk("R8 done cleared", {done_flag, irq}, 2'b00);
        int_en = 1'b0;

        // R5 and R10: commands and reads during busy are ignored
        issue(3'd3, 12'h200, '0);
        issue(3'd3, 12'h800, '0);
        issue(3'd1, 12'h900, 8'h00);
        @(negedge clk); rd_en = 1'b1; rd_addr = 12'h045;
        @(negedge clk); rd_en = 1'b0;
        chk("R10 no read while busy", rd_valid, 0);
        wait_idle();
        rd(12'h800, v, vl);
        chk("R5 erase ignored while busy", v, 8'h55);
        chk("R10 read valid when idle", vl, 1);
        pulse_done_clr();
        // R2 and R5: load was ignored and valid flags cleared, so program starts nothing
        issue(3'd2, '0, '0);
        chk("R2 empty program starts nothing", {busy, done_flag}, 2'b00);
        rd(12'h900, v, vl);
        chk("R5 load ignored while busy", v, 8'hFF);

        // R6: brown-out at issue
        issue(3'd1, 12'h045, 8'h00);
        brownout = 1'b1;
        issue(3'd2, '0, '0);
        chk("R6 not started", busy, 0);
        chk("R6 err bit0", err_flags, 2'b01);
        chk("R6 no done", done_flag, 0);
        rd(12'h045, v, vl);
        chk("R6 memory unchanged", v, 8'h30);
        // R9: sticky error bits
        repeat (10) @(negedge clk);
        chk("R9 err held", err_flags, 2'b01);
        pulse_err_clr(2'b10);
        chk("R9 other bit clear no effect", err_flags, 2'b01);
        pulse_err_clr(2'b01);
        chk("R9 err cleared", err_flags, 2'b00);

        // R7: brown-out mid-operation
        brownout = 1'b0;
        issue(3'd2, '0, '0);
        repeat (5) @(negedge clk);
        chk("R7 busy before abort", busy, 1);
        brownout = 1'b1;
        @(negedge clk);
        chk("R7 aborted", busy, 0);
        chk("R7 err bit1", err_flags, 2'b10);
        chk("R7 no done", done_flag, 0);
        rd(12'h045, v, vl);
        chk("R7 memory unchanged", v, 8'h30);
        brownout = 1'b0;
        pulse_err_clr(2'b10);
        chk("R9 err bit1 cleared", err_flags, 2'b00);

        // R7: buffer kept after abort, retry programs it
        issue(3'd2, '0, '0);
        wait_idle();
        rd(12'h045, v, vl);
        chk("R7 retry programs kept buffer", v, 8'h00);
        chk("R8 done after retry", done_flag, 1);

        // R3: chip erase
        issue(3'd6, '0, '0);
        wait_idle();
        rd(12'h045, v, vl);
        chk("R3 chip erase 045", v, 8'hFF);
        rd(12'h800, v, vl);
        chk("R3 chip erase 800", v, 8'hFF);
        rd(12'h123, v, vl);
        chk("R3 chip erase 123", v, 8'hFF);

        summary();
        $finish;
    end
endmodule